// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block arbitrates 256 interrupt vectors for one processor. Each vector can be made pending one at a time or in a 256-bit batch. The block keeps a pending set and an in-service set, and it always finds the highest-numbered member of each. From those two vectors and a task-priority register it decides whether the best pending vector may be taken now. If it may not, it reports whether the task priority or an in-service vector is holding it back.

Software acknowledges an interrupt by reading the vector port and retires it with an end-of-interrupt strobe. The block raises an interrupt request line and publishes an encoded priority for the best waiting vector. A threshold test compares that priority against a value built from the processor enable and the task-priority fields.

All checks run in a small sequencer with three states:
- `ST_IDLE`: no check is scheduled.
- `ST_PEND_CHK`: a pending check runs. It is entered on the edge after an accepted request, a batch, or a successful end-of-interrupt.
- `ST_THR_CHK`: a threshold check runs. It is entered on the edge after a task-priority write or a 0→1 change of the enable.

Every state moves to whichever check the current cycle's events call for, or back to `ST_IDLE`. A pending check takes precedence over a threshold check. A threshold check that is displaced this way is held and runs as soon as no pending check is due.

Top module: `vec_intc`

## Requirements
- R1: After reset, both vector sets are empty, the task-priority fields are 0, `irq` is 0, `prio_out` is 0, `mask_reason` is 0 and `ack_vec` shows the spurious value 15.
- R2: A single request whose value has any bit set above bit 7 is ignored. No vector becomes pending, and no check is scheduled.
- R3: `ack_vec` shows the highest pending vector when that vector is unmasked, and 15 otherwise. Pulsing `ack_rd` while a vector is shown has three effects: the vector moves from pending to in service, `prio_out` becomes 0, and `irq` becomes 0.
- R4: Special vectors are ranked in this order:
  - An in-service vector 2 masks everything (reason in-service).
  - Otherwise, a pending vector 2 is unmasked.
  - Otherwise, an in-service vector 0 masks everything (reason in-service).
  - Otherwise, a pending vector 0 is masked by task priority when the mask-all bit is 1, and unmasked when it is 0.
- R5: For ordinary vectors, the class is the vector shifted right by 4. The pending vector is higher when nothing is in service or when its class exceeds the in-service class.
  - If it is higher, the mask-all bit is 0 and its class exceeds the mask class, the result is unmasked.
  - If it is higher and either of those conditions fails, the result is masked by task priority.
  - If it is not higher, the result is masked by in-service.
  - The task-priority word holds the mask class in bits 7:4 and the mask-all bit in bit 16.
  - `mask_reason` reports the result: 0 means unmasked or nothing pending, 1 means task priority, 2 means in-service.
- R6: A pending check runs one cycle after a request, and it acts on the highest pending vector:
  - If the enable is 1 and the vector is unmasked, `irq` is set.
  - If it is masked by in-service, `prio_out` is left alone.
  - In any other case, `prio_out` is loaded with the vector's encoding.
- R7: The priority encoding is 32 for vector 2, 16 for vector 0, and the vector shifted right by 4 for every other vector. With nothing pending the value is 0.
- R8: An end-of-interrupt with something in service clears the highest in-service vector and runs a pending check one cycle later. With nothing in service it leaves state unchanged and pulses `eoi_err` for one cycle.
- R9: A threshold check runs one cycle after a task-priority write or a 0→1 change of `int_en`. The threshold is (not enable)·32 + mask-all·16 + mask class. When `prio_out` exceeds the threshold, `irq` is set and `prio_out` is cleared.
- R10: A batch write ORs all 256 bits into the pending set. It can be combined with a single request in the same cycle.
- R11: Among several pending vectors, the one with the highest index is presented first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| int_en | input | 1 | Processor interrupt enable |
| req_valid | input | 1 | Single-vector request strobe |
| req_vec | input | 12 | Requested vector value (ignored if above 255) |
| batch_valid | input | 1 | Batch request strobe |
| batch_bits | input | 256 | Vectors to OR into the pending set |
| tpr_we | input | 1 | Task-priority write strobe |
| tpr_wdata | input | 32 | Task-priority word (mask class 7:4, mask-all 16) |
| ack_rd | input | 1 | Vector read/acknowledge strobe |
| ack_vec | output | 8 | Vector a read returns now (15 = spurious) |
| eoi | input | 1 | End-of-interrupt strobe |
| irq | output | 1 | Interrupt request to the processor |
| prio_out | output | 6 | Encoded highest-pending priority |
| mask_reason | output | 2 | 0 unmasked, 1 task priority, 2 in-service |
| eoi_err | output | 1 | One-cycle pulse on end-of-interrupt with nothing in service |

## Verification
Some internal faults show up at once. A corrupted pending or in-service bit, or a wrong class comparison, changes `ack_vec` and `mask_reason` in the same cycle, because both are derived combinationally from the two sets and the task priority. Faults in the sequencer show up later. A missed or misrouted check leaves `irq` or `prio_out` wrong exactly one cycle after the triggering strobe. A lost in-service bit shows up later still: a later read returns a vector that ought to be blocked. The sweeps therefore sample the combinational outputs right after each stimulus and the registered outputs one edge later.

// File: rtl/vic_pkg.sv
package vic_pkg;

    typedef enum logic [1:0] {
        MASK_NONE  = 2'd0,
        MASK_TPR   = 2'd1,
        MASK_INSVC = 2'd2
    } mask_e;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_PEND_CHK = 2'd1,
        ST_THR_CHK  = 2'd2
    } st_e;

    localparam int PRIO_W   = 6;
    localparam int NMI_VEC  = 2;
    localparam int EXT_VEC  = 0;
    localparam int SPUR_VEC = 15;
    localparam int MIC_LSB  = 4;
    localparam int MMI_BIT  = 16;

endpackage

// File: rtl/vic_hi_find.sv
module vic_hi_find #(
    parameter int N     = 256,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     bits,
    output logic [IDX_W-1:0] idx,
    output logic             found
);
    // highest index wins: later hits overwrite earlier ones
    always_comb begin
        idx   = '0;
        found = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (bits[i]) begin
                idx   = IDX_W'(i);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/vic_mask_eval.sv
module vic_mask_eval
    import vic_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic [VEC_W-1:0] hp,
    input  logic             hp_ok,
    input  logic [VEC_W-1:0] hs,
    input  logic             hs_ok,
    input  logic [3:0]       mic,
    input  logic             mmi,
    output mask_e            reason
);
    localparam int CLS_W = VEC_W - 4;

    logic [CLS_W-1:0] hp_cls, hs_cls;
    logic             higher;

    assign hp_cls = hp[VEC_W-1:4];
    assign hs_cls = hs[VEC_W-1:4];
    assign higher = hp_ok && (!hs_ok || (hp_cls > hs_cls));

    always_comb begin
        if (hs_ok && hs == VEC_W'(NMI_VEC))
            reason = MASK_INSVC;
        else if (hp == VEC_W'(NMI_VEC))
            reason = MASK_NONE;
        else if (hs_ok && hs == VEC_W'(EXT_VEC))
            reason = MASK_INSVC;
        else if (hp == VEC_W'(EXT_VEC))
            reason = mmi ? MASK_TPR : MASK_NONE;
        else if (higher)
            reason = (!mmi && int'(hp_cls) > int'(mic)) ? MASK_NONE : MASK_TPR;
        else
            reason = MASK_INSVC;
    end
endmodule

// File: rtl/vic_prio_code.sv
module vic_prio_code
    import vic_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic [VEC_W-1:0]  vec,
    input  logic              ok,
    output logic [PRIO_W-1:0] code
);
    always_comb begin
        if (!ok)
            code = '0;
        else if (vec == VEC_W'(NMI_VEC))
            code = PRIO_W'(32);
        else if (vec == VEC_W'(EXT_VEC))
            code = PRIO_W'(16);
        else
            code = PRIO_W'(vec >> 4);
    end
endmodule

// File: rtl/vec_intc.sv
module vec_intc
    import vic_pkg::*;
#(
    parameter int VEC_W   = 8,
    parameter int NUM_VEC = 1 << VEC_W,
    parameter int REQ_W   = 12,
    parameter int TPR_W   = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               int_en,
    input  logic               req_valid,
    input  logic [REQ_W-1:0]   req_vec,
    input  logic               batch_valid,
    input  logic [NUM_VEC-1:0] batch_bits,
    input  logic               tpr_we,
    input  logic [TPR_W-1:0]   tpr_wdata,
    input  logic               ack_rd,
    output logic [VEC_W-1:0]   ack_vec,
    input  logic               eoi,
    output logic               irq,
    output logic [PRIO_W-1:0]  prio_out,
    output logic [1:0]         mask_reason,
    output logic               eoi_err
);
    logic [NUM_VEC-1:0] irr_q, isr_q;
    logic [3:0]         mic_q;
    logic               mmi_q, en_q, cond_hold_q;
    st_e                state_q, state_d;

    logic [VEC_W-1:0]   hp, hs;
    logic               hp_ok, hs_ok;
    mask_e              reason;
    logic [PRIO_W-1:0]  hp_code, thr;
    logic [NUM_VEC-1:0] req_bit, hp_bit, hs_bit;
    logic               req_ok, take, ack_go, eoi_go, cond_evt;
    logic               tpr_unused;

    assign tpr_unused = ^tpr_wdata;

    vic_hi_find #(.N(NUM_VEC), .IDX_W(VEC_W)) u_pend_find (
        .bits(irr_q), .idx(hp), .found(hp_ok));
    vic_hi_find #(.N(NUM_VEC), .IDX_W(VEC_W)) u_svc_find (
        .bits(isr_q), .idx(hs), .found(hs_ok));
    vic_mask_eval #(.VEC_W(VEC_W)) u_mask (
        .hp(hp), .hp_ok(hp_ok), .hs(hs), .hs_ok(hs_ok),
        .mic(mic_q), .mmi(mmi_q), .reason(reason));
    vic_prio_code #(.VEC_W(VEC_W)) u_code (
        .vec(hp), .ok(hp_ok), .code(hp_code));

    assign req_ok      = req_valid && ((req_vec >> VEC_W) == '0);
    assign take        = hp_ok && (reason == MASK_NONE);
    assign ack_go      = ack_rd && take;
    assign eoi_go      = eoi && hs_ok;
    assign cond_evt    = tpr_we || (int_en && !en_q);
    assign hp_bit      = NUM_VEC'(1) << hp;
    assign hs_bit      = NUM_VEC'(1) << hs;
    assign ack_vec     = take ? hp : VEC_W'(SPUR_VEC);
    assign mask_reason = hp_ok ? reason : MASK_NONE;
    assign thr         = {~int_en, mmi_q, mic_q};

    always_comb begin
        req_bit = '0;
        if (req_ok)
            req_bit[req_vec[VEC_W-1:0]] = 1'b1;
    end

    // next check to run
    always_comb begin
        if (req_ok || batch_valid || eoi_go)
            state_d = ST_PEND_CHK;
        else if (cond_evt || cond_hold_q)
            state_d = ST_THR_CHK;
        else
            state_d = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            cond_hold_q <= 1'b0;
            en_q        <= 1'b0;
        end else begin
            state_q     <= state_d;
            cond_hold_q <= (cond_evt || cond_hold_q) && (state_d != ST_THR_CHK);
            en_q        <= int_en;
        end
    end

    // vector sets and task priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irr_q <= '0;
            isr_q <= '0;
            mic_q <= '0;
            mmi_q <= 1'b0;
        end else begin
            irr_q <= (irr_q & ~(ack_go ? hp_bit : '0)) | req_bit
                     | (batch_valid ? batch_bits : '0);
            isr_q <= (isr_q & ~(eoi_go ? hs_bit : '0)) | (ack_go ? hp_bit : '0);
            if (tpr_we) begin
                mic_q <= tpr_wdata[MIC_LSB +: 4];
                mmi_q <= tpr_wdata[MMI_BIT];
            end
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq      <= 1'b0;
            prio_out <= '0;
            eoi_err  <= 1'b0;
        end else begin
            eoi_err <= eoi && !hs_ok;
            unique case (state_q)
                ST_PEND_CHK: begin
                    if (hp_ok) begin
                        if (int_en && reason == MASK_NONE)
                            irq <= 1'b1;
                        else if (reason != MASK_INSVC)
                            prio_out <= hp_code;
                    end
                end
                ST_THR_CHK: begin
                    if (prio_out > thr) begin
                        irq      <= 1'b1;
                        prio_out <= '0;
                    end
                end
                default: ;
            endcase
            if (ack_go) begin
                irq      <= 1'b0;
                prio_out <= '0;
            end
        end
    end
endmodule

// File: rtl/vec_intc_chk.sv
module vec_intc_chk
    import vic_pkg::*;
#(
    parameter int VEC_W = 8,
    parameter int REQ_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [REQ_W-1:0]  req_vec,
    input logic              batch_valid,
    input logic              tpr_we,
    input logic              ack_rd,
    input logic              eoi,
    input logic [VEC_W-1:0]  ack_vec,
    input logic [1:0]        mask_reason,
    input logic [PRIO_W-1:0] prio_out,
    input logic              irq,
    input logic              eoi_err,
    input st_e               state
);
    AST_BIG_REQ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_vec >> VEC_W) != '0 && !batch_valid && !tpr_we && !ack_rd && !eoi)
        |=> ($stable(ack_vec) && $stable(mask_reason))); // R2

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rd && ack_vec != VEC_W'(SPUR_VEC)) |=> (prio_out == '0 && !irq)); // R3

    AST_MASKED_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_reason != 2'd0) |-> (ack_vec == VEC_W'(SPUR_VEC))); // R5

    AST_PRIO_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (prio_out <= PRIO_W'(16)) || (prio_out == PRIO_W'(32))); // R7

    AST_EOI_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_err |-> $past(eoi)); // R8

    AST_IRQ_FROM_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(state) != ST_IDLE)); // R6
endmodule

bind vec_intc vec_intc_chk #(.VEC_W(VEC_W), .REQ_W(REQ_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vec(req_vec),
    .batch_valid(batch_valid), .tpr_we(tpr_we), .ack_rd(ack_rd), .eoi(eoi),
    .ack_vec(ack_vec), .mask_reason(mask_reason), .prio_out(prio_out),
    .irq(irq), .eoi_err(eoi_err), .state(state_q));

// File: tb/sim_vec_intc.sv
`timescale 1ns/1ps
module sim_vec_intc;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         int_en = 1'b0;
    logic         req_valid = 1'b0;
    logic [11:0]  req_vec = '0;
    logic         batch_valid = 1'b0;
    logic [255:0] batch_bits = '0;
    logic         tpr_we = 1'b0;
    logic [31:0]  tpr_wdata = '0;
    logic         ack_rd = 1'b0;
    logic [7:0]   ack_vec;
    logic         eoi = 1'b0;
    logic         irq;
    logic [5:0]   prio_out;
    logic [1:0]   mask_reason;
    logic         eoi_err;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    vec_intc u0 (
        .clk(clk), .rst_n(rst_n), .int_en(int_en), .req_valid(req_valid),
        .req_vec(req_vec), .batch_valid(batch_valid), .batch_bits(batch_bits),
        .tpr_we(tpr_we), .tpr_wdata(tpr_wdata), .ack_rd(ack_rd),
        .ack_vec(ack_vec), .eoi(eoi), .irq(irq), .prio_out(prio_out),
        .mask_reason(mask_reason), .eoi_err(eoi_err));

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; int_en = 1'b0; req_valid = 1'b0; batch_valid = 1'b0;
        tpr_we = 1'b0; ack_rd = 1'b0; eoi = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pend(input int v);
        req_vec = 12'(v); req_valid = 1'b1;
        @(negedge clk); req_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic batch(input logic [255:0] b);
        batch_bits = b; batch_valid = 1'b1;
        @(negedge clk); batch_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic wr_tpr(input int mic, input int mmi);
        tpr_wdata = (32'(mmi) << 16) | (32'(mic) << 4) | 32'hFFE0_F00F & 32'h0;
        tpr_we = 1'b1;
        @(negedge clk); tpr_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd(output int v);
        v = int'(ack_vec); ack_rd = 1'b1;
        @(negedge clk); ack_rd = 1'b0;
    endtask

    task automatic do_eoi(output int err);
        eoi = 1'b1;
        @(negedge clk); err = int'(eoi_err); eoi = 1'b0;
        @(negedge clk);
    endtask

    task automatic set_en(input logic b);
        int_en = b;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int got, err, exp_r;
        logic [255:0] model, pa, pb;
        do_reset();
        // R1 reset state
        check("R1 irq", int'(irq), 0);
        check("R1 prio", int'(prio_out), 0);
        check("R1 ack_vec", int'(ack_vec), 15);
        check("R1 reason", int'(mask_reason), 0);

        // R2 out-of-range single requests
        pend(256); pend(511); pend(4095);
        check("R2 ack_vec", int'(ack_vec), 15);
        check("R2 prio", int'(prio_out), 0);

        // R7/R6/R3 sweep of every vector, disabled, task priority 0
        for (int v = 0; v < 256; v++) begin
            do_reset();
            pend(v);
            check("R7 prio code", int'(prio_out),
                  (v == 2) ? 32 : (v == 0) ? 16 : (v >> 4));
            check("R3 ack_vec", int'(ack_vec),
                  (v == 0 || v == 2 || v >= 16) ? v : 15);
            if (v == 0 || v == 2 || v >= 16) begin
                rd(got);
                check("R3 read", got, v);
                check("R3 prio cleared", int'(prio_out), 0);
                check("R3 pending cleared", int'(ack_vec), 15);
            end
        end

        // R10/R11 batches drained in descending order
        for (int p = 0; p < 4; p++) begin
            do_reset();
            pa = '0; pb = '0;
            for (int i = 16; i < 256; i++) begin
                if ((i * 7 + p * 13) % 5 == 0) pa[i] = 1'b1;
                if ((i * 3 + p) % 11 == 0)     pb[i] = 1'b1;
            end
            batch(pa);
            req_vec = 12'(17 + p); req_valid = 1'b1;
            batch_bits = pb; batch_valid = 1'b1;
            @(negedge clk); req_valid = 1'b0; batch_valid = 1'b0;
            @(negedge clk);
            model = pa | pb;
            model[17 + p] = 1'b1;
            while (model != '0) begin
                exp_r = 0;
                for (int i = 0; i < 256; i++) if (model[i]) exp_r = i;
                rd(got);
                check("R11 highest first", got, exp_r);
                model[exp_r] = 1'b0;
                do_eoi(err);
                check("R10 eoi ok", err, 0);
            end
            check("R10 drained", int'(ack_vec), 15);
        end

        // R5 class / mask class / mask-all sweep
        for (int ci = 0; ci < 16; ci++)
            for (int cp = 1; cp < 16; cp++)
                for (int mic = 0; mic < 16; mic++)
                    for (int mmi = 0; mmi < 2; mmi++) begin
                        do_reset();
                        if (ci > 0) begin
                            pend(ci * 16);
                            rd(got);
                        end
                        wr_tpr(mic, mmi);
                        pend(cp * 16 + 3);
                        if (ci == 0 || cp > ci)
                            exp_r = (mmi == 0 && cp > mic) ? 0 : 1;
                        else
                            exp_r = 2;
                        check("R5 reason", int'(mask_reason), exp_r);
                        check("R5 ack_vec", int'(ack_vec),
                              (exp_r == 0) ? cp * 16 + 3 : 15);
                    end

        // R4 special vectors
        do_reset();
        pend(2); rd(got);
        check("R4 nmi taken", got, 2);
        pend(80);
        check("R4 nmi in service masks", int'(mask_reason), 2);
        do_reset();
        pend(0); rd(got);
        check("R4 ext taken", got, 0);
        pend(2);
        check("R4 nmi beats ext", int'(mask_reason), 0);
        check("R4 nmi shown", int'(ack_vec), 2);
        rd(got);
        pend(128);
        check("R4 nmi in service masks 2", int'(mask_reason), 2);
        do_reset();
        wr_tpr(0, 1); pend(0);
        check("R4 ext masked by mask-all", int'(mask_reason), 1);
        wr_tpr(0, 0);
        check("R4 ext unmasked", int'(ack_vec), 0);
        do_reset();
        pend(48); rd(got); pend(0);
        check("R4 ext over ordinary", int'(ack_vec), 0);
        do_reset();
        wr_tpr(15, 1); pend(2);
        check("R4 nmi ignores tpr", int'(ack_vec), 2);

        // R6 pending check actions
        do_reset();
        set_en(1'b1);
        check("R6 no irq idle", int'(irq), 0);
        pend(64);
        check("R6 irq set", int'(irq), 1);
        check("R6 prio held", int'(prio_out), 0);
        rd(got);
        check("R3 irq cleared", int'(irq), 0);
        set_en(1'b0);
        pend(32);
        check("R6 insvc keeps prio", int'(prio_out), 0);
        check("R6 insvc no irq", int'(irq), 0);
        wr_tpr(5, 0);
        do_eoi(err);
        check("R8 eoi ok", err, 0);
        check("R8 recheck prio", int'(prio_out), 2);
        do_reset();
        wr_tpr(5, 0); pend(64);
        check("R6 tpr mask updates prio", int'(prio_out), 4);

        // R9 threshold checks
        do_reset();
        pend(112);
        check("R9 prio 7", int'(prio_out), 7);
        wr_tpr(8, 0);
        check("R9 disabled no irq", int'(irq), 0);
        set_en(1'b1);
        check("R9 below mic", int'(irq), 0);
        wr_tpr(3, 0);
        check("R9 tpr write raises", int'(irq), 1);
        check("R9 prio cleared", int'(prio_out), 0);
        do_reset();
        pend(112); wr_tpr(3, 0);
        check("R9 disabled threshold", int'(irq), 0);
        set_en(1'b1);
        check("R9 enable rise raises", int'(irq), 1);
        do_reset();
        pend(2); wr_tpr(15, 1);
        set_en(1'b1);
        check("R9 nmi over mask-all", int'(irq), 1);

        // R8 end-of-interrupt
        do_reset();
        do_eoi(err);
        check("R8 eoi empty error", err, 1);
        check("R8 error one cycle", int'(eoi_err), 0);
        pend(128); rd(got); pend(64);
        set_en(1'b1);
        check("R8 blocked before eoi", int'(irq), 0);
        do_eoi(err);
        check("R8 eoi no error", err, 0);
        check("R8 recheck raises irq", int'(irq), 1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule